// File: doc/BRIEF.md
# Legacy VGA Indexed Register Port

This block is the I/O register front end of a legacy VGA display controller. It receives 8-bit reads and writes from a synchronous I/O bus in the 3B0h–3DFh address range and steers them into four banks of indexed registers: sequencer, graphics controller, attribute controller and CRT controller. It also handles a few registers that are addressed directly: miscellaneous output, feature control and palette mask. The two input status bytes come in on ports and are returned on reads.

Three of the banks use a pair of ports, one holding an index and one reaching the register that the index selects. The attribute bank has a single write port. A toggle inside the block decides whether a write to that port loads the index or stores data. Several addresses decode differently for reads and for writes. Bit 0 of the miscellaneous output register moves the CRT controller and input-status-1 ports between the 3Bxh window (monochrome) and the 3Dxh window (colour). Every stored value is exported so that display logic elsewhere can use it.

Top module: `vga_io_port`

## Requirements
- R1: After reset all stored registers and indices are 00h, `io_rdata` is 00h and the attribute toggle is in the index state.
- R2: A write takes effect at the clock edge that samples `io_wr`. The read result appears on `io_rdata` at the edge that samples `io_rd` and stays unchanged until the next read. If `io_wr` and `io_rd` are both high, only the write is performed.
- R3: The sequencer index is at 3C4h and its data at 3C5h. Implemented indices are 00h–04h and 07h. Each exported bank bus holds its implemented indices in ascending order, the k-th of them at bits 8k+7:8k.
- R4: The graphics controller index is at 3CEh and its data at 3CFh. Implemented indices are 00h–08h, 10h, 11h and 18h.
- R5: The CRT controller index/data pair is at 3D4h/3D5h when miscellaneous output bit 0 is 1, and at 3B4h/3B5h when that bit is 0. Implemented indices are 00h–18h and 22h.
- R6: The deselected window (3B0h–3BFh in colour mode, 3D0h–3DFh in monochrome mode) reads FFh, and writes to it change nothing.
- R7: Writes to 3C0h alternate between the attribute index and the attribute data, starting with the index. Implemented attribute indices are 00h–14h. Data reads back at 3C1h, and writes to 3C1h are ignored.
- R8: A read of 3C0h returns the attribute index and leaves the toggle unchanged. A read of input status 1 (3DAh in colour mode, 3BAh in monochrome mode) returns `stat1_in` and forces the toggle to the index state.
- R9: A write to 3C2h loads the miscellaneous output register. A read of 3C2h returns `stat0_in`, and a read of 3CCh returns the miscellaneous output register.
- R10: A write to the selected input-status-1 address loads feature control. Feature control reads back at 3CAh, and writes to 3CAh are ignored.
- R11: The palette mask is read and written at 3C6h.
- R12: Reserved addresses inside 3C0h–3CFh or the selected window, any address outside 3B0h–3DFh, and unimplemented bank indices all read 00h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| stat0_in | input | 8 | Value returned for input status 0 |
| stat1_in | input | 8 | Value returned for input status 1 |
| misc_out | output | 8 | Miscellaneous output register |
| feat_out | output | 8 | Feature control register |
| pmask_out | output | 8 | Palette mask register |
| seq_regs_o | output | 48 | Sequencer registers, packed by slot |
| gfx_regs_o | output | 96 | Graphics controller registers, packed by slot |
| attr_regs_o | output | 168 | Attribute registers, packed by slot |
| crtc_regs_o | output | 208 | CRT controller registers, packed by slot |

## Verification
Every result is due exactly one clock edge after its stimulus. Read data appears on `io_rdata` at the edge that samples `io_rd`. A write's new value appears on the exported buses at the edge that samples `io_wr`. A toggle or index change shows up in the next access. The bench drives each access on a falling edge and samples on the following falling edge, when the one register stage has settled. Between accesses the strobes are low, so the hold behaviour of `io_rdata` and of the stored state is checked in the same way.

// File: rtl/vga_io_pkg.sv
package vga_io_pkg;

  typedef enum logic [1:0] {BK_SEQ, BK_GFX, BK_ATT, BK_CRT} bank_kind_e;

  typedef struct packed {
    logic       hit;
    logic [4:0] slot;
  } slot_map_t;

  typedef enum logic [3:0] {
    RS_ZERO, RS_ONES, RS_ATT_IDX, RS_ATT_DAT, RS_STAT0, RS_STAT1,
    RS_SEQ_IDX, RS_SEQ_DAT, RS_GFX_IDX, RS_GFX_DAT, RS_CRT_IDX,
    RS_CRT_DAT, RS_PMASK, RS_FEAT, RS_MISC
  } rsel_e;

  typedef struct packed {
    logic  seq_iw;
    logic  seq_dw;
    logic  gfx_iw;
    logic  gfx_dw;
    logic  crt_iw;
    logic  crt_dw;
    logic  att_iw;
    logic  att_dw;
    logic  misc_w;
    logic  feat_w;
    logic  pmask_w;
    logic  stat1_rd;
    logic  rd_en;
    rsel_e rsel;
  } dec_t;

  // Number of implemented registers per bank
  function automatic int bank_slots(bank_kind_e k);
    case (k)
      BK_SEQ:  return 6;
      BK_GFX:  return 12;
      BK_ATT:  return 21;
      default: return 26;
    endcase
  endfunction

  // Index to storage slot; slots follow ascending index order
  function automatic slot_map_t map_index(bank_kind_e k, logic [7:0] idx);
    slot_map_t m;
    m.hit  = 1'b0;
    m.slot = 5'd0;
    case (k)
      BK_SEQ: begin
        if (idx < 8'h05) begin m.hit = 1'b1; m.slot = idx[4:0]; end
        else if (idx == 8'h07) begin m.hit = 1'b1; m.slot = 5'd5; end
      end
      BK_GFX: begin
        if (idx < 8'h09) begin m.hit = 1'b1; m.slot = idx[4:0]; end
        else if (idx == 8'h10) begin m.hit = 1'b1; m.slot = 5'd9; end
        else if (idx == 8'h11) begin m.hit = 1'b1; m.slot = 5'd10; end
        else if (idx == 8'h18) begin m.hit = 1'b1; m.slot = 5'd11; end
      end
      BK_ATT: begin
        if (idx < 8'h15) begin m.hit = 1'b1; m.slot = idx[4:0]; end
      end
      default: begin
        if (idx < 8'h19) begin m.hit = 1'b1; m.slot = idx[4:0]; end
        else if (idx == 8'h22) begin m.hit = 1'b1; m.slot = 5'd25; end
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vga_io_decode.sv
module vga_io_decode
  import vga_io_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              colour,
  input  logic              att_data_phase,
  output dec_t              dec
);

  logic [ADDR_W-1:0] win;
  logic              win_b, win_c, win_d, sel_crt, desel;
  logic              rd_en;

  always_comb begin
    win     = addr >> 4;
    win_b   = (win == ADDR_W'(12'h03B));
    win_c   = (win == ADDR_W'(12'h03C));
    win_d   = (win == ADDR_W'(12'h03D));
    sel_crt = (win_b && !colour) || (win_d && colour);
    desel   = (win_b && colour) || (win_d && !colour);
    rd_en   = rd && !wr;

    dec       = '0;
    dec.rd_en = rd_en;
    dec.rsel  = RS_ZERO;

    if (desel) begin
      dec.rsel = RS_ONES;
    end else if (win_c) begin
      case (addr[3:0])
        4'h0: begin
          dec.att_iw = wr && !att_data_phase;
          dec.att_dw = wr && att_data_phase;
          dec.rsel   = RS_ATT_IDX;
        end
        4'h1: dec.rsel = RS_ATT_DAT;
        4'h2: begin dec.misc_w  = wr; dec.rsel = RS_STAT0;   end
        4'h4: begin dec.seq_iw  = wr; dec.rsel = RS_SEQ_IDX; end
        4'h5: begin dec.seq_dw  = wr; dec.rsel = RS_SEQ_DAT; end
        4'h6: begin dec.pmask_w = wr; dec.rsel = RS_PMASK;   end
        4'hA: dec.rsel = RS_FEAT;
        4'hC: dec.rsel = RS_MISC;
        4'hE: begin dec.gfx_iw  = wr; dec.rsel = RS_GFX_IDX; end
        4'hF: begin dec.gfx_dw  = wr; dec.rsel = RS_GFX_DAT; end
        default: dec.rsel = RS_ZERO;
      endcase
    end else if (sel_crt) begin
      case (addr[3:0])
        4'h4: begin dec.crt_iw = wr; dec.rsel = RS_CRT_IDX; end
        4'h5: begin dec.crt_dw = wr; dec.rsel = RS_CRT_DAT; end
        4'hA: begin
          dec.feat_w   = wr;
          dec.stat1_rd = rd_en;
          dec.rsel     = RS_STAT1;
        end
        default: dec.rsel = RS_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/vga_reg_bank.sv
module vga_reg_bank
  import vga_io_pkg::*;
#(
  parameter bank_kind_e KIND = BK_SEQ,
  localparam int NSLOT = bank_slots(KIND)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic               dat_we,
  input  logic [7:0]         wdata,
  output logic [7:0]         idx_q,
  output logic [7:0]         rd_data,
  output logic [NSLOT*8-1:0] regs_flat
);

  logic [7:0]       idx_d;
  slot_map_t        sm;
  logic [NSLOT-1:0] slot_en;
  logic [7:0]       slot_q [NSLOT];

  always_comb begin
    idx_d = idx_we ? wdata : idx_q;
    sm    = map_index(KIND, idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= 8'h00;
    else        idx_q <= idx_d;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_en[g] = dat_we && sm.hit && (sm.slot == 5'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[g] <= 8'h00;
      else if (slot_en[g]) slot_q[g] <= wdata;
    end

    assign regs_flat[g*8 +: 8] = slot_q[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int s = 0; s < NSLOT; s++) begin
      if (sm.hit && (sm.slot == 5'(s))) rd_data = slot_q[s];
    end
  end

  AST_BANK_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_we && sm.hit) |=> $stable(regs_flat)); // R12

  AST_BANK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && sm.hit && !idx_we) |=> (rd_data == $past(wdata))); // R3

endmodule

// File: rtl/vga_attr_flip.sv
module vga_attr_flip (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  output logic data_phase
);

  logic data_phase_d;

  always_comb begin
    data_phase_d = data_phase;
    if (clr)      data_phase_d = 1'b0;
    else if (adv) data_phase_d = !data_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_phase <= 1'b0;
    else        data_phase <= data_phase_d;
  end

  AST_FLIP_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (data_phase != $past(data_phase))); // R7

  AST_FLIP_STAT1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !data_phase); // R8

  AST_FLIP_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(data_phase)); // R8

endmodule

// File: rtl/vga_io_port.sv
module vga_io_port
  import vga_io_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    io_addr,
  input  logic [7:0]                           io_wdata,
  input  logic                                 io_wr,
  input  logic                                 io_rd,
  output logic [7:0]                           io_rdata,
  input  logic [7:0]                           stat0_in,
  input  logic [7:0]                           stat1_in,
  output logic [7:0]                           misc_out,
  output logic [7:0]                           feat_out,
  output logic [7:0]                           pmask_out,
  output logic [bank_slots(BK_SEQ)*8-1:0]      seq_regs_o,
  output logic [bank_slots(BK_GFX)*8-1:0]      gfx_regs_o,
  output logic [bank_slots(BK_ATT)*8-1:0]      attr_regs_o,
  output logic [bank_slots(BK_CRT)*8-1:0]      crtc_regs_o
);

  dec_t       dec;
  logic       att_data_phase;
  logic [7:0] misc_q, misc_d, feat_q, feat_d, pmask_q, pmask_d;
  logic [7:0] rdata_q, rdata_d, rd_mux;
  logic [7:0] seq_idx, seq_rd, gfx_idx, gfx_rd, att_idx, att_rd, crt_idx, crt_rd;

  vga_io_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr           (io_addr),
    .wr             (io_wr),
    .rd             (io_rd),
    .colour         (misc_q[0]),
    .att_data_phase (att_data_phase),
    .dec            (dec)
  );

  vga_attr_flip i_flip (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (dec.att_iw || dec.att_dw),
    .clr        (dec.stat1_rd),
    .data_phase (att_data_phase)
  );

  vga_reg_bank #(.KIND(BK_SEQ)) i_seq (
    .clk(clk), .rst_n(rst_n), .idx_we(dec.seq_iw), .dat_we(dec.seq_dw),
    .wdata(io_wdata), .idx_q(seq_idx), .rd_data(seq_rd), .regs_flat(seq_regs_o)
  );

  vga_reg_bank #(.KIND(BK_GFX)) i_gfx (
    .clk(clk), .rst_n(rst_n), .idx_we(dec.gfx_iw), .dat_we(dec.gfx_dw),
    .wdata(io_wdata), .idx_q(gfx_idx), .rd_data(gfx_rd), .regs_flat(gfx_regs_o)
  );

  vga_reg_bank #(.KIND(BK_ATT)) i_att (
    .clk(clk), .rst_n(rst_n), .idx_we(dec.att_iw), .dat_we(dec.att_dw),
    .wdata(io_wdata), .idx_q(att_idx), .rd_data(att_rd), .regs_flat(attr_regs_o)
  );

  vga_reg_bank #(.KIND(BK_CRT)) i_crt (
    .clk(clk), .rst_n(rst_n), .idx_we(dec.crt_iw), .dat_we(dec.crt_dw),
    .wdata(io_wdata), .idx_q(crt_idx), .rd_data(crt_rd), .regs_flat(crtc_regs_o)
  );

  // Directly addressed registers: next state
  always_comb begin
    misc_d  = dec.misc_w  ? io_wdata : misc_q;
    feat_d  = dec.feat_w  ? io_wdata : feat_q;
    pmask_d = dec.pmask_w ? io_wdata : pmask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q  <= 8'h00;
      feat_q  <= 8'h00;
      pmask_q <= 8'h00;
    end else begin
      misc_q  <= misc_d;
      feat_q  <= feat_d;
      pmask_q <= pmask_d;
    end
  end

  // Read return select
  always_comb begin
    case (dec.rsel)
      RS_ONES:    rd_mux = 8'hFF;
      RS_ATT_IDX: rd_mux = att_idx;
      RS_ATT_DAT: rd_mux = att_rd;
      RS_STAT0:   rd_mux = stat0_in;
      RS_STAT1:   rd_mux = stat1_in;
      RS_SEQ_IDX: rd_mux = seq_idx;
      RS_SEQ_DAT: rd_mux = seq_rd;
      RS_GFX_IDX: rd_mux = gfx_idx;
      RS_GFX_DAT: rd_mux = gfx_rd;
      RS_CRT_IDX: rd_mux = crt_idx;
      RS_CRT_DAT: rd_mux = crt_rd;
      RS_PMASK:   rd_mux = pmask_q;
      RS_FEAT:    rd_mux = feat_q;
      RS_MISC:    rd_mux = misc_q;
      default:    rd_mux = 8'h00;
    endcase
    rdata_d = dec.rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 8'h00;
    else        rdata_q <= rdata_d;
  end

  assign io_rdata  = rdata_q;
  assign misc_out  = misc_q;
  assign feat_out  = feat_q;
  assign pmask_out = pmask_q;

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && !io_wr) |=> $stable(io_rdata)); // R2

  AST_STROBES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec.seq_iw, dec.seq_dw, dec.gfx_iw, dec.gfx_dw, dec.crt_iw,
              dec.crt_dw, dec.att_iw, dec.att_dw, dec.misc_w, dec.feat_w,
              dec.pmask_w})); // R2

  AST_DESEL_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr &&
     ((misc_q[0] && ((io_addr >> 4) == ADDR_W'(12'h03B))) ||
      (!misc_q[0] && ((io_addr >> 4) == ADDR_W'(12'h03D)))))
    |=> (io_rdata == 8'hFF)); // R6

  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr &&
     ((io_addr < ADDR_W'(12'h3B0)) || (io_addr > ADDR_W'(12'h3DF))))
    |=> (io_rdata == 8'h00)); // R12

  AST_MISC_ONLY_3C2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && (io_addr == ADDR_W'(12'h3C2))) |=> $stable(misc_out)); // R9

  AST_STAT0_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && (io_addr == ADDR_W'(12'h3C2)))
    |=> (io_rdata == $past(stat0_in))); // R9

endmodule

// File: tb/test_vga_io_port.sv
`timescale 1ns/1ps
module test_vga_io_port;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  io_addr;
  logic [7:0]   io_wdata, io_rdata, stat0_in, stat1_in;
  logic         io_wr, io_rd;
  logic [7:0]   misc_out, feat_out, pmask_out;
  logic [47:0]  seq_regs_o;
  logic [95:0]  gfx_regs_o;
  logic [167:0] attr_regs_o;
  logic [207:0] crtc_regs_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  vga_io_port #(.ADDR_W(16)) i_vga_io_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .stat0_in(stat0_in), .stat1_in(stat1_in),
    .misc_out(misc_out), .feat_out(feat_out), .pmask_out(pmask_out),
    .seq_regs_o(seq_regs_o), .gfx_regs_o(gfx_regs_o),
    .attr_regs_o(attr_regs_o), .crtc_regs_o(crtc_regs_o)
  );

  // Reference model: bank 0 seq, 1 gfx, 2 attr, 3 crtc
  logic [7:0] mreg [4][256];
  logic [7:0] mix  [4];
  logic [7:0] mmisc, mfeat, mpm;
  bit         mflip;

  function automatic bit impl(int b, int idx);
    case (b)
      0: return (idx <= 4) || (idx == 7);
      1: return (idx <= 8) || (idx == 'h10) || (idx == 'h11) || (idx == 'h18);
      2: return (idx <= 'h14);
      default: return (idx <= 'h18) || (idx == 'h22);
    endcase
  endfunction

  function automatic logic [207:0] pack_bank(int b);
    logic [207:0] r = '0;
    int k = 0;
    for (int i = 0; i < 256; i++) begin
      if (impl(b, i)) begin
        r[k*8 +: 8] = mreg[b][i];
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] crt_base();
    return mmisc[0] ? 16'h3D0 : 16'h3B0;
  endfunction

  function automatic bit desel_addr(logic [15:0] a);
    return ((a >> 4) == 16'h03B && mmisc[0]) || ((a >> 4) == 16'h03D && !mmisc[0]);
  endfunction

  function automatic string tag_of(logic [15:0] a);
    if (desel_addr(a)) return "R6";
    if (a == 16'h3C0 || a == 16'h3C1) return "R7";
    if (a == 16'h3C2 || a == 16'h3CC) return "R9";
    if (a == 16'h3C4 || a == 16'h3C5) return "R3";
    if (a == 16'h3CE || a == 16'h3CF) return "R4";
    if (a == 16'h3C6) return "R11";
    if (a == 16'h3CA) return "R10";
    if (a == crt_base() + 16'h4 || a == crt_base() + 16'h5) return "R5";
    if (a == crt_base() + 16'hA) return "R8";
    return "R12";
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] cb = crt_base();
    if (desel_addr(a)) return;
    if (a == 16'h3C0) begin
      if (!mflip) mix[2] = d;
      else if (impl(2, mix[2])) mreg[2][mix[2]] = d;
      mflip = !mflip;
    end
    else if (a == 16'h3C2) mmisc = d;
    else if (a == 16'h3C4) mix[0] = d;
    else if (a == 16'h3C5) begin if (impl(0, mix[0])) mreg[0][mix[0]] = d; end
    else if (a == 16'h3CE) mix[1] = d;
    else if (a == 16'h3CF) begin if (impl(1, mix[1])) mreg[1][mix[1]] = d; end
    else if (a == 16'h3C6) mpm = d;
    else if (a == cb + 16'h4) mix[3] = d;
    else if (a == cb + 16'h5) begin if (impl(3, mix[3])) mreg[3][mix[3]] = d; end
    else if (a == cb + 16'hA) mfeat = d;
  endtask

  task automatic model_read(input logic [15:0] a, output logic [7:0] e);
    logic [15:0] cb = crt_base();
    e = 8'h00;
    if (desel_addr(a)) e = 8'hFF;
    else if (a == 16'h3C0) e = mix[2];
    else if (a == 16'h3C1) e = impl(2, mix[2]) ? mreg[2][mix[2]] : 8'h00;
    else if (a == 16'h3C2) e = stat0_in;
    else if (a == 16'h3C4) e = mix[0];
    else if (a == 16'h3C5) e = impl(0, mix[0]) ? mreg[0][mix[0]] : 8'h00;
    else if (a == 16'h3CE) e = mix[1];
    else if (a == 16'h3CF) e = impl(1, mix[1]) ? mreg[1][mix[1]] : 8'h00;
    else if (a == 16'h3C6) e = mpm;
    else if (a == 16'h3CA) e = mfeat;
    else if (a == 16'h3CC) e = mmisc;
    else if (a == cb + 16'h4) e = mix[3];
    else if (a == cb + 16'h5) e = impl(3, mix[3]) ? mreg[3][mix[3]] : 8'h00;
    else if (a == cb + 16'hA) begin e = stat1_in; mflip = 0; end
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_exports(input string tag);
    logic [207:0] s = pack_bank(0), g = pack_bank(1);
    logic [207:0] t = pack_bank(2), c = pack_bank(3);
    logic [207:0] act = {seq_regs_o, gfx_regs_o[63:0], misc_out, feat_out, pmask_out};
    logic [207:0] exp = {s[47:0], g[63:0], mmisc, mfeat, mpm};
    checks++;
    if (act !== exp || gfx_regs_o[95:64] !== g[95:64] ||
        attr_regs_o !== t[167:0] || crtc_regs_o !== c) begin
      errors++;
      $display("FAIL %s exports actual seq %h gfx %h attr %h crtc %h misc %02h feat %02h pm %02h expected seq %h gfx %h attr %h crtc %h misc %02h feat %02h pm %02h",
               tag, seq_regs_o, gfx_regs_o, attr_regs_o, crtc_regs_o, misc_out, feat_out, pmask_out,
               s[47:0], g[95:0], t[167:0], c, mmisc, mfeat, mpm);
    end
  endtask

  // One bus access: drive at falling edge, sample at the next falling edge
  task automatic bus(input bit w, input bit r, input logic [15:0] a,
                     input logic [7:0] d, input string tag);
    logic [7:0] e;
    logic [7:0] prev = io_rdata;
    io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
    if (w) model_write(a, d);
    else if (r) model_read(a, e);
    @(negedge clk);
    io_wr = 0; io_rd = 0;
    if (r && !w) check8(tag, io_rdata, e);
    if (r && w)  check8(tag, io_rdata, prev);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus(1, 0, a, d, "");
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    bus(0, 1, a, 8'h00, tag);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; io_wr = 0; io_rd = 0; io_addr = '0; io_wdata = '0;
    stat0_in = 8'h5C; stat1_in = 8'h09;
    for (int b = 0; b < 4; b++) begin
      mix[b] = 8'h00;
      for (int i = 0; i < 256; i++) mreg[b][i] = 8'h00;
    end
    mmisc = 0; mfeat = 0; mpm = 0; mflip = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check8("R1", io_rdata, 8'h00);
    check_exports("R1");
    rd(16'h3CC, "R1");
    rd(16'h3D4, "R6");              // monochrome after reset
    rd(16'h3B4, "R5");

    // R9: miscellaneous output and status 0
    wr(16'h3C2, 8'h01);
    rd(16'h3CC, "R9");
    rd(16'h3C2, "R9");
    check_exports("R9");

    // R7/R8: attribute toggle
    wr(16'h3C0, 8'h05);
    wr(16'h3C0, 8'hAB);
    rd(16'h3C0, "R8");
    rd(16'h3C1, "R7");
    wr(16'h3C1, 8'h77);
    rd(16'h3C1, "R7");
    wr(16'h3C0, 8'h11);
    rd(16'h3C0, "R8");
    wr(16'h3C0, 8'h3C);
    rd(16'h3C1, "R8");
    wr(16'h3C0, 8'h12);
    rd(16'h3DA, "R8");
    wr(16'h3C0, 8'h13);
    rd(16'h3C0, "R8");
    wr(16'h3C0, 8'h14);
    wr(16'h3C0, 8'hE7);
    rd(16'h3C1, "R7");
    check_exports("R7");

    // R3/R4: sequencer and graphics controller
    wr(16'h3C4, 8'h07); wr(16'h3C5, 8'h5A); rd(16'h3C5, "R3");
    wr(16'h3C4, 8'h05); wr(16'h3C5, 8'h99); rd(16'h3C5, "R12");
    rd(16'h3C4, "R3");
    wr(16'h3CE, 8'h18); wr(16'h3CF, 8'h42); rd(16'h3CF, "R4");
    wr(16'h3CE, 8'h12); wr(16'h3CF, 8'h24); rd(16'h3CF, "R12");
    check_exports("R3");

    // R5/R6/R10: CRTC and window selection
    wr(16'h3D4, 8'h22); wr(16'h3D5, 8'hC3); rd(16'h3D5, "R5");
    rd(16'h3B5, "R6");
    wr(16'h3B4, 8'h01);
    rd(16'h3D4, "R6");
    wr(16'h3C2, 8'h00);
    rd(16'h3B5, "R5");
    rd(16'h3D4, "R6");
    wr(16'h3BA, 8'h0F); rd(16'h3CA, "R10");
    wr(16'h3DA, 8'hF0); rd(16'h3CA, "R6");
    wr(16'h3CA, 8'h33); rd(16'h3CA, "R10");
    rd(16'h3BA, "R8");
    check_exports("R6");

    // R11/R12: palette mask and reserved addresses
    wr(16'h3C6, 8'hA5); rd(16'h3C6, "R11");
    wr(16'h3C3, 8'h66); rd(16'h3C3, "R12");
    wr(16'h0080, 8'h66); rd(16'h0080, "R12");
    rd(16'h3BF, "R12");
    check_exports("R12");

    // R2: simultaneous strobes perform only the write
    bus(1, 1, 16'h3C4, 8'h03, "R2");
    rd(16'h3C4, "R2");

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int p = $urandom % 100;
      if (n % 64 == 0) begin stat0_in = 8'($urandom); stat1_in = 8'($urandom); end
      case ($urandom % 16)
        0:  a = 16'h3C0;  1: a = 16'h3C1;  2: a = 16'h3C2;  3: a = 16'h3C4;
        4:  a = 16'h3C5;  5: a = 16'h3C6;  6: a = 16'h3CA;  7: a = 16'h3CC;
        8:  a = 16'h3CE;  9: a = 16'h3CF; 10: a = 16'h3B4; 11: a = 16'h3B5;
        12: a = 16'h3BA; 13: a = 16'h3D4; 14: a = 16'h3D5;
        default: a = 16'h3DA;
      endcase
      if (p >= 85) a = 16'h3B0 + 16'($urandom % 48);
      if (p >= 97) a = 16'($urandom);
      d = ($urandom % 2) ? 8'($urandom % 40) : 8'($urandom);
      if ($urandom % 2) wr(a, d);
      else rd(a, tag_of(a));
      if (n % 32 == 31) check_exports("R2");
    end
    check_exports("R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule